// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block puts a one-time-programmable fuse array behind a small set of 32-bit registers. Software first chooses a target by writing a byte address and a bit position into the address register. A read command then copies the chosen array byte into the data register. Programming sets a single fuse bit, and only after a two-word unlock sequence. A programmed fuse never returns to zero. The array is held in internal storage, and reset leaves its contents untouched. A test port can preload array bytes directly.

Three redundant 32-bit copies of the strap word are kept in the first twelve array bytes. A dedicated read-only register returns their bitwise majority, so one corrupted copy is outvoted. The data register rejects every write except one clear value. The command register never reads back its contents.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the register reads are status 0x00000001, configuration 0x20000000, and zero for address, data, strap-independent command and all other registers.
- R2: The address register (offset 0x04) holds the byte address in bits 9:0 and the bit position in bits 12:10, and reads back those 13 bits with the upper bits zero.
- R3: Writing 0x00000002 to the command register (offset 0x14) loads the addressed array byte into the data register (offset 0x08) on the next clock and sets status bit 1 (done) and bit 0 (ready).
- R4: Writing 0x00000001 to the command register and then 0xBF79E5D0 as the very next command write sets the addressed bit of the addressed byte and sets status bits 1 and 0.
- R5: The second program word has no effect on the array or status unless the command write just before it was 0x00000001; any other command write in between cancels the unlock.
- R6: Programming only ORs a 1 into the array; bits already at 1 stay 1 and no other bit of the byte changes.
- R7: A write of 0x00000001 to the data register clears it to zero; every other value written there is ignored.
- R8: In the status register (offset 0x00) bit 0 is read-only, bit 1 is cleared by writing 1 to it, and bit 2 is a plain read/write bit; bits 31:3 read zero.
- R9: Offset 0x10 returns the bitwise majority of three little-endian 32-bit words held in array bytes 0-3, 4-7 and 8-11; writes to it are ignored.
- R10: The command register reads as zero, and any read of an unmapped or misaligned offset returns zero while a write there changes nothing.
- R11: The configuration register (offset 0x0C) is a plain 32-bit read/write register.
- R12: When a backdoor preload and a program operation hit the same byte in the same cycle, the stored byte is the preload value OR the programmed bit.
- R13: Reset does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | BUS_AW | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| bd_we | input | 1 | Backdoor array byte write |
| bd_addr | input | AW | Backdoor byte address |
| bd_data | input | 8 | Backdoor byte value |

## Verification
The bus carries only one register access per cycle, so the only two functions that can meet in one cycle are a program operation and a backdoor preload into the array. The bench arms the sequence and then issues the second program word on the same clock edge as a backdoor write to the same byte. It then reads the byte back through a read command and expects the preload value ORed with the programmed bit. A second collision places the two writes on different bytes, and both updates must land.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  // Register byte offsets
  localparam logic [15:0] OFS_STATUS = 16'h0000;
  localparam logic [15:0] OFS_ADDR   = 16'h0004;
  localparam logic [15:0] OFS_DATA   = 16'h0008;
  localparam logic [15:0] OFS_CFG    = 16'h000C;
  localparam logic [15:0] OFS_STRAP  = 16'h0010;
  localparam logic [15:0] OFS_CMD    = 16'h0014;

  // Command and magic words
  localparam logic [31:0] CMD_READ   = 32'h0000_0002;
  localparam logic [31:0] CMD_ARM    = 32'h0000_0001;
  localparam logic [31:0] CMD_PROG   = 32'hBF79_E5D0;
  localparam logic [31:0] DATA_WIPE  = 32'h0000_0001;

  // Address register layout
  localparam int BYTE_FLD_W  = 10;
  localparam int BIT_FLD_LSB = 10;
  localparam int BIT_FLD_W   = 3;
  localparam int ADDR_REG_W  = BYTE_FLD_W + BIT_FLD_W;

  localparam logic [31:0] CFG_RST = 32'h2000_0000;

  // Status bits
  typedef struct packed {
    logic ien;
    logic done;
    logic rdy;
  } fuse_status_t;

  localparam int STRAP_COPIES = 3;
  localparam int STRAP_W      = 32;
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_val,
  output logic        rd_go,
  output logic        prog_go,
  output logic        armed
);
  logic armed_d;

  always_comb begin
    armed_d = armed;
    if (cmd_wr) armed_d = (cmd_val == CMD_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (cmd_wr) armed <= armed_d;
  end

  assign rd_go   = cmd_wr && (cmd_val == CMD_READ);
  assign prog_go = cmd_wr && (cmd_val == CMD_PROG) && armed;
endmodule

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               bd_we,
  input  logic [AW-1:0]      bd_addr,
  input  logic [7:0]         bd_data,
  input  logic               set_en,
  input  logic [AW-1:0]      set_addr,
  input  logic [2:0]         set_bit,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_byte,
  output logic [STRAP_W-1:0] strap
);
  localparam int STRAP_BYTES = STRAP_W / 8;

  logic [7:0] mem [DEPTH];
  logic [7:0] set_mask;
  logic       same_byte;
  logic [STRAP_W-1:0] copy_w [STRAP_COPIES];

  assign set_mask  = 8'(1) << set_bit;
  assign same_byte = bd_we && set_en && (bd_addr == set_addr);

  always_ff @(posedge clk) begin
    if (bd_we)
      mem[bd_addr] <= bd_data | (same_byte ? set_mask : 8'h00);
    if (set_en && !same_byte)
      mem[set_addr] <= mem[set_addr] | set_mask;
  end

  assign rd_byte = mem[rd_addr];

  // Assemble the redundant little-endian copies
  for (genvar c = 0; c < STRAP_COPIES; c++) begin : g_copy
    for (genvar b = 0; b < STRAP_BYTES; b++) begin : g_byte
      assign copy_w[c][8*b +: 8] = mem[c*STRAP_BYTES + b];
    end
  end

  // Bitwise two-of-three vote
  for (genvar i = 0; i < STRAP_W; i++) begin : g_vote
    assign strap[i] = (copy_w[0][i] & copy_w[1][i]) |
                      (copy_w[0][i] & copy_w[2][i]) |
                      (copy_w[1][i] & copy_w[2][i]);
  end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BUS_AW = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bd_we,
  input  logic [AW-1:0]     bd_addr,
  input  logic [7:0]        bd_data
);
  // Reset: asynchronous assert, synchronous release
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  // Decode
  logic wr, rd;
  logic hit_st, hit_ad, hit_dt, hit_cf, hit_sp, hit_cm;
  assign wr = reg_en && reg_we;
  assign rd = reg_en && !reg_we;
  assign hit_st = (reg_addr == BUS_AW'(OFS_STATUS));
  assign hit_ad = (reg_addr == BUS_AW'(OFS_ADDR));
  assign hit_dt = (reg_addr == BUS_AW'(OFS_DATA));
  assign hit_cf = (reg_addr == BUS_AW'(OFS_CFG));
  assign hit_sp = (reg_addr == BUS_AW'(OFS_STRAP));
  assign hit_cm = (reg_addr == BUS_AW'(OFS_CMD));

  // State
  fuse_status_t          st_q, st_d;
  logic [ADDR_REG_W-1:0] addr_q;
  logic [7:0]            data_q, data_d;
  logic [31:0]           cfg_q;
  logic                  st_en, ad_en, dt_en, cf_en;

  logic rd_go, prog_go, armed;
  logic [7:0]         rd_byte;
  logic [STRAP_W-1:0] strap;

  fuse_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmd_wr  (wr && hit_cm),
    .cmd_val (reg_wdata),
    .rd_go   (rd_go),
    .prog_go (prog_go),
    .armed   (armed)
  );

  fuse_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .bd_we    (bd_we),
    .bd_addr  (bd_addr),
    .bd_data  (bd_data),
    .set_en   (prog_go),
    .set_addr (addr_q[AW-1:0]),
    .set_bit  (addr_q[BIT_FLD_LSB +: BIT_FLD_W]),
    .rd_addr  (addr_q[AW-1:0]),
    .rd_byte  (rd_byte),
    .strap    (strap)
  );

  // Next state
  always_comb begin
    st_d = st_q;
    if (wr && hit_st) begin
      st_d.ien = reg_wdata[2];
      if (reg_wdata[1]) st_d.done = 1'b0;
    end
    if (rd_go || prog_go) begin
      st_d.done = 1'b1;
      st_d.rdy  = 1'b1;
    end
    data_d = data_q;
    if (rd_go) data_d = rd_byte;
    else if (wr && hit_dt && reg_wdata == DATA_WIPE) data_d = 8'h00;
  end

  assign st_en = (wr && hit_st) || rd_go || prog_go;
  assign dt_en = rd_go || (wr && hit_dt);
  assign ad_en = wr && hit_ad;
  assign cf_en = wr && hit_cf;

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= '{ien: 1'b0, done: 1'b0, rdy: 1'b1};
      addr_q <= '0;
      data_q <= '0;
      cfg_q  <= CFG_RST;
    end else begin
      if (st_en) st_q   <= st_d;
      if (ad_en) addr_q <= reg_wdata[ADDR_REG_W-1:0];
      if (dt_en) data_q <= data_d;
      if (cf_en) cfg_q  <= reg_wdata;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      if (hit_st)      reg_rdata = 32'(st_q);
      else if (hit_ad) reg_rdata = 32'(addr_q);
      else if (hit_dt) reg_rdata = 32'(data_q);
      else if (hit_cf) reg_rdata = cfg_q;
      else if (hit_sp) reg_rdata = strap;
    end
  end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk
  import fuse_pkg::*;
#(
  parameter int BUS_AW = 12
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              reg_en,
  input logic              reg_we,
  input logic [BUS_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [2:0]        st_q,
  input logic [7:0]        data_q,
  input logic              armed
);
  logic cmd_wr, wipe_wr;
  assign cmd_wr  = reg_en && reg_we && (reg_addr == BUS_AW'(OFS_CMD));
  assign wipe_wr = reg_en && reg_we && (reg_addr == BUS_AW'(OFS_DATA))
                   && (reg_wdata == DATA_WIPE);

  // R3: read command leaves done and ready set
  a_r3_read_sets_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_wr && reg_wdata == CMD_READ) |=> (st_q[1:0] == 2'b11));

  // R5: the unlock state only comes from the first program word
  a_r5_arm_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(armed) |-> $past(cmd_wr && reg_wdata == CMD_ARM));

  // R7: data register moves only on a read command or the clear word
  a_r7_data_guarded: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cmd_wr && !wipe_wr) |=> $stable(data_q));

  // R8: ready bit stays at one
  a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    st_q[0]);

  // R10: command offset reads zero
  a_r10_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_en && !reg_we && reg_addr == BUS_AW'(OFS_CMD)) |-> (reg_rdata == 32'h0));
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.BUS_AW(BUS_AW)) u_fuse_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .st_q      (st_q),
  .data_q    (data_q),
  .armed     (armed)
);

// File: tb/test_fuse_ctrl.sv
`timescale 1ns/1ps
module test_fuse_ctrl;
  localparam int DEPTH  = 1024;
  localparam int BUS_AW = 12;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_en, reg_we;
  logic [BUS_AW-1:0] reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              bd_we;
  logic [AW-1:0]     bd_addr;
  logic [7:0]        bd_data;

  always #10 clk = ~clk;

  fuse_ctrl #(.DEPTH(DEPTH), .BUS_AW(BUS_AW)) i_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [DEPTH];
  logic       ien_m;
  logic       done_m;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = BUS_AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = BUS_AW'(a);
    #2 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic bd(int a, logic [7:0] v);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = AW'(a); bd_data = v;
    @(negedge clk);
    bd_we = 1'b0;
    model[a] = v;
  endtask

  function automatic logic [31:0] strap_exp();
    logic [31:0] w0, w1, w2;
    w0 = {model[3], model[2], model[1], model[0]};
    w1 = {model[7], model[6], model[5], model[4]};
    w2 = {model[11], model[10], model[9], model[8]};
    return (w0 & w1) | (w0 & w2) | (w1 & w2);
  endfunction

  function automatic logic [31:0] st_exp();
    return {29'h0, ien_m, done_m, 1'b1};
  endfunction

  task automatic fetch(int a, string tag);
    logic [31:0] v;
    wr(16'h0004, 32'(a));
    wr(16'h0014, 32'h2);
    done_m = 1'b1;
    rd(16'h0008, v);
    chk(tag, v, 32'(model[a]));
  endtask

  task automatic prog(int a, int b);
    wr(16'h0004, 32'(a) | (32'(b) << 10));
    wr(16'h0014, 32'h1);
    wr(16'h0014, 32'hBF79E5D0);
    model[a] = model[a] | (8'(1) << b);
    done_m = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ien_m = 1'b0; done_m = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a, b, op;
    v = $urandom(32'd4711);
    reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    bd_we = 0; bd_addr = '0; bd_data = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    do_reset();

    // R1 reset values
    rd(16'h0000, v); chk("R1 status", v, 32'h1);
    rd(16'h000C, v); chk("R1 cfg", v, 32'h2000_0000);
    rd(16'h0004, v); chk("R1 addr", v, 32'h0);
    rd(16'h0008, v); chk("R1 data", v, 32'h0);

    // preload array through backdoor
    for (int i = 0; i < 64; i++) bd(i, 8'($urandom()));
    bd(DEPTH - 1, 8'h5A);

    // R2 address field readback
    wr(16'h0004, 32'hFFFF_FFFF);
    rd(16'h0004, v); chk("R2 addr mask", v, 32'h0000_1FFF);

    // R3 read command
    fetch(DEPTH - 1, "R3 read top byte");
    rd(16'h0000, v); chk("R3 status done", v, st_exp());

    // R8 status bits
    wr(16'h0000, 32'hFFFF_FFFF); ien_m = 1'b1; done_m = 1'b0;
    rd(16'h0000, v); chk("R8 w1c and ien", v, st_exp());
    wr(16'h0000, 32'h0); ien_m = 1'b0;
    rd(16'h0000, v); chk("R8 ien clear", v, st_exp());

    // R4 program, R6 already-one bit
    bd(40, 8'h00);
    prog(40, 7);
    fetch(40, "R4 program bit 7");
    bd(41, 8'hF0);
    prog(41, 5);
    fetch(41, "R6 set bit stays");
    prog(41, 0);
    fetch(41, "R6 or in bit 0");

    // R5 broken sequence
    wr(16'h0000, 32'h2); done_m = 1'b0;
    wr(16'h0004, 32'd42 | (32'd3 << 10));
    wr(16'h0014, 32'h1);
    wr(16'h0014, 32'h0);
    wr(16'h0014, 32'hBF79E5D0);
    rd(16'h0000, v); chk("R5 no done", v, st_exp());
    wr(16'h0014, 32'hBF79E5D0);
    fetch(42, "R5 unarmed no change");

    // R7 data register writes
    fetch(41, "R7 setup");
    wr(16'h0008, 32'h0000_0003);
    rd(16'h0008, v); chk("R7 ignore", v, 32'(model[41]));
    wr(16'h0008, 32'h1);
    rd(16'h0008, v); chk("R7 clear", v, 32'h0);

    // R9 strap vote and ignored write
    rd(16'h0010, v); chk("R9 strap", v, strap_exp());
    bd(0, 8'hFF); bd(4, 8'h00); bd(8, 8'h0F);
    rd(16'h0010, v); chk("R9 strap vote", v, strap_exp());
    wr(16'h0010, 32'hDEAD_BEEF);
    rd(16'h0010, v); chk("R9 write ignored", v, strap_exp());

    // R10 command and unmapped
    wr(16'h0014, 32'h1);
    rd(16'h0014, v); chk("R10 cmd zero", v, 32'h0);
    wr(16'h0014, 32'h0);
    wr(16'h0020, 32'hFFFF_FFFF);
    wr(16'h000D, 32'hFFFF_FFFF);
    rd(16'h0020, v); chk("R10 unmapped read", v, 32'h0);
    rd(16'h0006, v); chk("R10 misaligned read", v, 32'h0);
    rd(16'h000C, v); chk("R10 cfg untouched", v, 32'h2000_0000);

    // R11 configuration
    wr(16'h000C, 32'h1234_5678);
    rd(16'h000C, v); chk("R11 cfg rw", v, 32'h1234_5678);

    // R12 collision, same byte then different bytes
    wr(16'h0004, 32'd5 | (32'd0 << 10));
    wr(16'h0014, 32'h1);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = BUS_AW'(16'h0014); reg_wdata = 32'hBF79E5D0;
    bd_we = 1; bd_addr = AW'(5); bd_data = 8'h10;
    @(negedge clk);
    reg_en = 0; reg_we = 0; bd_we = 0;
    model[5] = 8'h11;
    fetch(5, "R12 same byte merge");
    wr(16'h0004, 32'd6 | (32'd2 << 10));
    wr(16'h0014, 32'h1);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = BUS_AW'(16'h0014); reg_wdata = 32'hBF79E5D0;
    bd_we = 1; bd_addr = AW'(7); bd_data = 8'hA5;
    @(negedge clk);
    reg_en = 0; reg_we = 0; bd_we = 0;
    model[6] = model[6] | 8'h04; model[7] = 8'hA5;
    fetch(6, "R12 program side");
    fetch(7, "R12 backdoor side");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      op = int'($urandom_range(0, 3));
      a  = int'($urandom_range(0, 63));
      b  = int'($urandom_range(0, 7));
      case (op)
        0: fetch(a, "R3 random read");
        1: begin prog(a, b); fetch(a, "R4 random program"); end
        2: begin
          wr(16'h0004, 32'(a) | (32'(b) << 10));
          wr(16'h0014, 32'h1);
          wr(16'h0014, 32'h2); done_m = 1'b1;
          wr(16'h0014, 32'hBF79E5D0);
          fetch(a, "R5 random broken");
        end
        default: begin
          rd(16'h0010, v); chk("R9 random strap", v, strap_exp());
        end
      endcase
    end
    rd(16'h0000, v); chk("R8 status after mix", v, st_exp());

    // R13 array retained over reset
    do_reset();
    rd(16'h0000, v); chk("R1 status after reset", v, 32'h1);
    fetch(41, "R13 array kept");
    rd(16'h0010, v); chk("R13 strap kept", v, strap_exp());

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule